// File: doc/BRIEF.md
# Fast interrupt context shadow registers

This block holds a single saved copy of three core registers: a 5-bit status register, an 8-bit working register and a 4-bit bank-select register. The core presents their live values every cycle. Whenever an interrupt is vectored, whatever its priority, the block copies the three values into its shadow. A fast-call strobe from the subroutine path does the same. A fast interrupt return or a fast subroutine return sends the shadow back to the core. One cycle later the block drives the saved values on its restore outputs and raises a one-cycle restore-valid strobe.

The shadow has one level only and sits on no software-visible bus. Every capture replaces whatever was saved before. If a high-priority interrupt arrives while a low-priority handler is still running, it overwrites the context that the low-priority entry saved. The block follows which interrupt levels are active. It raises a one-cycle warning whenever a capture lands while a low-priority context is marked active, so the core or a debugger can see that the saved copy was lost.

Top module: `fast_ctx_shadow`

## Requirements
- R1: After reset the restore outputs are all zero and restore_vld_o and ovwr_warn_o are low.
- R2: An interrupt vector strobe (irq_vec_i = 1) copies status_i, wreg_i and bsr_i into the shadow, for either value of irq_hi_i (1 = high priority, 0 = low priority).
- R3: A fast interrupt return strobe (fast_retfie_i) makes restore_vld_o high for exactly the next cycle, with status_o, wreg_o and bsr_o equal to the shadow contents as they stood at the strobe.
- R4: A fast call strobe (fast_call_i) captures the three registers, and a later fast return strobe (fast_ret_i) restores them with the same one-cycle timing as R3.
- R5: The shadow has one level: each capture replaces the previous one, so a high-priority vector taken during a low-priority handler makes a following fast restore return the high-priority entry values.
- R6: A normal interrupt return (retfie_i) asserts no restore_vld_o and leaves the restore outputs unchanged.
- R7: When a capture and a restore strobe occur in the same cycle, the restore outputs carry the shadow values from before that cycle, and the shadow then holds the newly captured values.
- R8: ovwr_warn_o is high for exactly the cycle after a capture (vector or fast call) taken while a low-priority interrupt is active. A low-priority vector marks that context active. Any interrupt return, fast or normal, ends the high-priority context if one is active, and otherwise ends the low-priority context.
- R9: Outside restore cycles the restore outputs keep the last restored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 5 | Live status register value |
| wreg_i | input | 8 | Live working register value |
| bsr_i | input | 4 | Live bank-select register value |
| irq_vec_i | input | 1 | Interrupt vectoring strobe |
| irq_hi_i | input | 1 | Priority of the vectored interrupt, 1 = high |
| fast_call_i | input | 1 | Fast subroutine call strobe (capture) |
| fast_retfie_i | input | 1 | Fast interrupt return strobe (restore) |
| fast_ret_i | input | 1 | Fast subroutine return strobe (restore) |
| retfie_i | input | 1 | Normal interrupt return strobe (no restore) |
| status_o | output | 5 | Restored status value |
| wreg_o | output | 8 | Restored working register value |
| bsr_o | output | 4 | Restored bank-select value |
| restore_vld_o | output | 1 | One-cycle strobe, restore values are valid |
| ovwr_warn_o | output | 1 | One-cycle warning, a low-priority context was overwritten |

## Verification
The bench nests a high-priority vector inside a low-priority handler. A design that kept a second level, or that ignored the high-priority capture, would return the low-priority values there, and one that failed to track priorities would miss the warning pulse or raise it spuriously when only a high-priority context is active. It issues a fast return and a fast call in the same cycle. A design that forwarded the new values would restore them one return too early. It also issues normal returns between fast ones. A design that treated them as fast would pulse restore-valid or disturb the held outputs.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned STAT_W_DEF = 5;
  localparam int unsigned WREG_W_DEF = 8;
  localparam int unsigned BSR_W_DEF  = 4;

  typedef enum logic {
    PRIO_LO = 1'b0,
    PRIO_HI = 1'b1
  } prio_e;
endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fcs_shadow_store.sv
module fcs_shadow_store #(
  parameter int unsigned CTX_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [CTX_W-1:0] cap_data,
  output logic [CTX_W-1:0] shadow_q
);
  logic [CTX_W-1:0] shadow_d;

  always_comb begin
    shadow_d = shadow_q;
    if (cap_en) shadow_d = cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  // R5: a capture leaves exactly the captured values in the single level
  a_r5_single_level: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (shadow_q == $past(cap_data)));

  // R2: with no capture the saved context does not move
  a_r2_hold_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(shadow_q));
endmodule

// File: rtl/fcs_restore_port.sv
module fcs_restore_port #(
  parameter int unsigned CTX_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_en,
  input  logic [CTX_W-1:0] shadow,
  output logic [CTX_W-1:0] data_q,
  output logic             vld_q
);
  logic [CTX_W-1:0] data_d;
  logic             vld_d;

  always_comb begin
    data_d = data_q;
    vld_d  = rst_en;
    if (rst_en) data_d = shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  // R9: outputs only move in a restore cycle
  a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(data_q));
endmodule

// File: rtl/fcs_prio_track.sv
module fcs_prio_track
  import fcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_vec,
  input  prio_e irq_prio,
  input  logic capture,
  input  logic int_ret,
  output logic lo_act_q,
  output logic warn_q
);
  logic hi_act_q;
  logic lo_act_d;
  logic hi_act_d;
  logic warn_d;

  always_comb begin
    lo_act_d = lo_act_q;
    hi_act_d = hi_act_q;
    warn_d   = capture && lo_act_q;
    if (int_ret) begin
      if (hi_act_q) hi_act_d = 1'b0;
      else          lo_act_d = 1'b0;
    end
    if (irq_vec) begin
      if (irq_prio == PRIO_HI) hi_act_d = 1'b1;
      else                     lo_act_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_act_q <= 1'b0;
      hi_act_q <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      lo_act_q <= lo_act_d;
      hi_act_q <= hi_act_d;
      warn_q   <= warn_d;
    end
  end

  // R8: a warning pulse is a single cycle unless captures keep arriving
  a_r8_warn_single: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && !$past(capture, 2)) |=> !warn_q || $past(capture));

  // R8: a low-priority vector always marks the low context active
  a_r8_lo_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec && irq_prio == PRIO_LO) |=> lo_act_q);
endmodule

// File: rtl/fast_ctx_shadow.sv
module fast_ctx_shadow
  import fcs_pkg::*;
#(
  parameter int unsigned STAT_W = STAT_W_DEF,
  parameter int unsigned WREG_W = WREG_W_DEF,
  parameter int unsigned BSR_W  = BSR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_i,
  input  logic [WREG_W-1:0] wreg_i,
  input  logic [BSR_W-1:0]  bsr_i,
  input  logic              irq_vec_i,
  input  logic              irq_hi_i,
  input  logic              fast_call_i,
  input  logic              fast_retfie_i,
  input  logic              fast_ret_i,
  input  logic              retfie_i,
  output logic [STAT_W-1:0] status_o,
  output logic [WREG_W-1:0] wreg_o,
  output logic [BSR_W-1:0]  bsr_o,
  output logic              restore_vld_o,
  output logic              ovwr_warn_o
);
  localparam int unsigned CTX_W = STAT_W + WREG_W + BSR_W;

  logic             rst_sync_n;
  logic             capture;
  logic             restore;
  logic             int_ret;
  logic [CTX_W-1:0] live_ctx;
  logic [CTX_W-1:0] shadow;
  logic [CTX_W-1:0] out_ctx;
  logic             lo_act;
  prio_e            irq_prio;

  always_comb begin
    capture  = irq_vec_i || fast_call_i;
    restore  = fast_retfie_i || fast_ret_i;
    int_ret  = fast_retfie_i || retfie_i;
    live_ctx = {status_i, wreg_i, bsr_i};
    irq_prio = irq_hi_i ? PRIO_HI : PRIO_LO;
  end

  fcs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  fcs_shadow_store #(.CTX_W(CTX_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .cap_en(capture),
    .cap_data(live_ctx), .shadow_q(shadow)
  );

  fcs_restore_port #(.CTX_W(CTX_W)) u_restore (
    .clk(clk), .rst_n(rst_sync_n), .rst_en(restore),
    .shadow(shadow), .data_q(out_ctx), .vld_q(restore_vld_o)
  );

  fcs_prio_track u_track (
    .clk(clk), .rst_n(rst_sync_n), .irq_vec(irq_vec_i),
    .irq_prio(irq_prio), .capture(capture), .int_ret(int_ret),
    .lo_act_q(lo_act), .warn_q(ovwr_warn_o)
  );

  assign {status_o, wreg_o, bsr_o} = out_ctx;

  // R3: every fast return strobe is answered one cycle later
  a_r3_vld_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restore |=> restore_vld_o);

  // R6: no restore strobe, no restore-valid
  a_r6_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !restore |=> !restore_vld_o);

  // R7: simultaneous capture and restore returns the older context
  a_r7_old_on_collision: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (restore && capture) |=> (out_ctx == $past(shadow)) && (shadow == $past(live_ctx)));

  // R8: a warning always has a capture under an active low context behind it
  a_r8_warn_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovwr_warn_o |-> $past(capture) && $past(lo_act));
endmodule

// File: tb/fast_ctx_shadow_tb.sv
module fast_ctx_shadow_tb;
  localparam int SW = 5;
  localparam int WW = 8;
  localparam int BW = 4;

  typedef struct {
    logic          vld;
    logic [SW-1:0] st;
    logic [WW-1:0] w;
    logic [BW-1:0] b;
    logic          warn;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] status_i = '0;
  logic [WW-1:0] wreg_i = '0;
  logic [BW-1:0] bsr_i = '0;
  logic irq_vec_i = 1'b0, irq_hi_i = 1'b0, fast_call_i = 1'b0;
  logic fast_retfie_i = 1'b0, fast_ret_i = 1'b0, retfie_i = 1'b0;
  logic [SW-1:0] status_o;
  logic [WW-1:0] wreg_o;
  logic [BW-1:0] bsr_o;
  logic restore_vld_o, ovwr_warn_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t q[$];

  logic [SW-1:0] m_st = '0, o_st = '0;
  logic [WW-1:0] m_w = '0, o_w = '0;
  logic [BW-1:0] m_b = '0, o_b = '0;
  bit m_lo = 0, m_hi = 0;

  fast_ctx_shadow u_dut (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .wreg_i(wreg_i), .bsr_i(bsr_i),
    .irq_vec_i(irq_vec_i), .irq_hi_i(irq_hi_i), .fast_call_i(fast_call_i),
    .fast_retfie_i(fast_retfie_i), .fast_ret_i(fast_ret_i), .retfie_i(retfie_i),
    .status_o(status_o), .wreg_o(wreg_o), .bsr_o(bsr_o),
    .restore_vld_o(restore_vld_o), .ovwr_warn_o(ovwr_warn_o)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit irq, input bit hi, input bit fcall, input bit fretfie,
                      input bit fret, input bit ret, input logic [SW-1:0] st,
                      input logic [WW-1:0] w, input logic [BW-1:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    irq_vec_i = irq; irq_hi_i = hi; fast_call_i = fcall;
    fast_retfie_i = fretfie; fast_ret_i = fret; retfie_i = ret;
    status_i = st; wreg_i = w; bsr_i = b;
    e.vld = fretfie | fret;
    if (e.vld) begin o_st = m_st; o_w = m_w; o_b = m_b; end
    e.st = o_st; e.w = o_w; e.b = o_b;
    e.warn = (irq | fcall) & m_lo;
    e.tag = tag;
    q.push_back(e);
    if (irq | fcall) begin m_st = st; m_w = w; m_b = b; end
    if (fretfie | ret) begin
      if (m_hi) m_hi = 0; else m_lo = 0;
    end
    if (irq) begin
      if (hi) m_hi = 1; else m_lo = 1;
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 5'h1f, 8'hee, 4'hd, tag);
  endtask

  // Scoreboard monitor: one expectation per driven cycle, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(restore_vld_o == e.vld, e.tag, "restore_vld", restore_vld_o, e.vld);
        check(status_o == e.st, e.tag, "status", status_o, e.st);
        check(wreg_o == e.w, e.tag, "wreg", wreg_o, e.w);
        check(bsr_o == e.b, e.tag, "bsr", bsr_o, e.b);
        check(ovwr_warn_o == e.warn, e.tag, "warn", ovwr_warn_o, e.warn);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    check(restore_vld_o == 0, "R1", "restore_vld", restore_vld_o, 0);
    check(ovwr_warn_o == 0, "R1", "warn", ovwr_warn_o, 0);
    check({status_o, wreg_o, bsr_o} == 0, "R1", "outputs", {status_o, wreg_o, bsr_o}, 0);

    // R2, R3: low-priority vector then fast interrupt return
    step(1, 0, 0, 0, 0, 0, 5'h0a, 8'h5c, 4'h3, "R2");
    idle("R9");
    step(0, 0, 0, 1, 0, 0, 5'h00, 8'h00, 4'h0, "R3");
    idle("R9");
    // R2: high-priority vector captures too
    step(1, 1, 0, 0, 0, 0, 5'h15, 8'ha7, 4'h9, "R2");
    step(0, 0, 0, 1, 0, 0, 5'h00, 8'h00, 4'h0, "R2");
    // R4: fast call and fast return
    step(0, 0, 1, 0, 0, 0, 5'h11, 8'h3e, 4'hc, "R4");
    idle("R9");
    step(0, 0, 0, 0, 1, 0, 5'h00, 8'h00, 4'h0, "R4");
    // R5, R8: nested high-priority vector overwrites low-priority save
    step(1, 0, 0, 0, 0, 0, 5'h07, 8'h12, 4'h1, "R5");
    step(1, 1, 0, 0, 0, 0, 5'h18, 8'hf0, 4'he, "R8");
    step(0, 0, 0, 1, 0, 0, 5'h00, 8'h00, 4'h0, "R5");
    // R6: normal return ends low context, no restore
    step(0, 0, 0, 0, 0, 1, 5'h00, 8'h00, 4'h0, "R6");
    idle("R6");
    // R8: fast call with no low context active gives no warning
    step(0, 0, 1, 0, 0, 0, 5'h02, 8'h44, 4'h5, "R8");
    // R7: capture and restore in the same cycle
    step(0, 0, 1, 0, 1, 0, 5'h1c, 8'h99, 4'h7, "R7");
    step(0, 0, 0, 0, 1, 0, 5'h00, 8'h00, 4'h0, "R7");
    // R8: high context only, then a fast call: no warning
    step(1, 1, 0, 0, 0, 0, 5'h0f, 8'h81, 4'h2, "R8");
    step(0, 0, 1, 0, 0, 0, 5'h03, 8'h66, 4'h8, "R8");
    step(0, 0, 0, 0, 0, 1, 5'h00, 8'h00, 4'h0, "R6");
    // R8: low context then fast call warns; fast retfie restores the call values
    step(1, 0, 0, 0, 0, 0, 5'h09, 8'h21, 4'h4, "R2");
    step(0, 0, 1, 0, 0, 0, 5'h1e, 8'hbd, 4'h6, "R8");
    step(0, 0, 0, 1, 0, 0, 5'h00, 8'h00, 4'h0, "R3");
    step(0, 0, 1, 0, 0, 0, 5'h01, 8'h02, 4'h3, "R8");
    idle("R9");
    idle("R9");
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule